// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and letting a third table of counters choose between them for each branch. The local component is a table of saturating counters addressed only by the branch address. The global component is a table of the same shape, addressed by the branch address XOR-combined with a shift register that records the most recent resolved outcomes. A chooser table, addressed like the local component, holds a 2-bit counter per entry. Its upper half selects the global component and its lower half selects the local one.

A front end sends a branch word address on the lookup request stream. One cycle later the block returns the final direction, both component opinions and the chooser's choice on the response stream. The response is held until the consumer takes it. Back-pressure works like this: `req_ready` is high whenever no response is waiting or the waiting one is taken in the same cycle. A request offered while `req_ready` is low must be held, unchanged, until it is accepted.

When a branch resolves, the back end pulses `upd_valid` with the branch address, the real outcome and the two component opinions it received at lookup. The update is a plain strobe that is accepted in every cycle. It trains both components, moves the chooser toward the component that was right when the two disagreed, and shifts the outcome into the history. The address ports carry a word address: alignment bits are already removed. All address bits are XOR-folded into the table index.

Top module: `tourney_pred`

## Requirements
- R1: While `rst_n` is low and after its release, every local and global counter holds weakly not-taken (value 2^(CTR_W-1)-1), every chooser counter holds 1, the history is all zero and `rsp_valid` is 0. A first lookup therefore returns `rsp_p0`=0, `rsp_p1`=0, `rsp_sel`=0 and `rsp_taken`=0.
- R2: `rsp_p0` is the top bit of the local counter at index fold(pc). fold XORs together the IDX_W-bit slices of the address, with the lowest slice at bits [IDX_W-1:0]. A value of 1 means taken.
- R3: `rsp_p1` is the top bit of the global counter at index fold(pc) XOR fold(history), where 1 means taken.
- R4: `rsp_sel` is 1, meaning the global component, when the chooser counter at fold(pc) is 2 or 3. It is 0, meaning the local component, when that counter is 0 or 1.
- R5: `rsp_taken` equals `rsp_p1` when `rsp_sel` is 1 and equals `rsp_p0` when `rsp_sel` is 0.
- R6: Every `upd_valid` cycle trains two entries, whichever component had been selected. The local entry is at fold(upd_pc). The global entry is at fold(upd_pc) XOR fold(history before that update). Each counter increments, saturating at its maximum, when `upd_taken` is 1. It decrements, saturating at 0, when `upd_taken` is 0.
- R7: The chooser entry at fold(upd_pc) changes only when `upd_p0` differs from `upd_p1`. It increments, saturating at 3, when `upd_p1` equals `upd_taken`. It decrements, saturating at 0, otherwise.
- R8: Every `upd_valid` cycle shifts the history left by one place and puts `upd_taken` into bit 0.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `rsp_valid` is 1 after that edge. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, every response output holds its value.
- R10: When a lookup is accepted in the same cycle as an update, the response reflects the tables and history as they stood before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup request can be taken |
| req_pc | input | PC_W | Branch word address to predict |
| rsp_valid | output | 1 | Prediction response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Final predicted direction, 1 = taken |
| rsp_p0 | output | 1 | Local component opinion |
| rsp_p1 | output | 1 | Global component opinion |
| rsp_sel | output | 1 | Component chosen, 1 = global |
| upd_valid | input | 1 | Resolved branch strobe |
| upd_pc | input | PC_W | Word address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_p0 | input | 1 | Local opinion returned at lookup |
| upd_p1 | input | 1 | Global opinion returned at lookup |

## Verification
Directed sequences first train a chooser entry with updates where the two components disagree. This separates the chooser from the components: the final direction then follows the global opinion even though the local one says the opposite. Updates where the components agree, and updates where the local component was right, show that the chooser stays put in the first case and steps back in the second. A lookup sent in the same cycle as an update on the same address tells old state from new. Two lookups of one address on either side of a history change tell the global index apart from the local one. A long mixed phase then compares every output, every cycle, against a behavioural model. In that phase, addresses alias through the fold, the consumer stalls at random, and the opinions fed back are arbitrary.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic {
    SRC_LOCAL  = 1'b0,
    SRC_GLOBAL = 1'b1
  } src_e;

  typedef struct packed {
    logic taken;
    logic p0;
    logic p1;
    src_e src;
  } pred_s;

endpackage

// File: rtl/tp_fold.sv
module tp_fold #(
  parameter int IN_W  = 30,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int CHUNKS = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD    = CHUNKS * OUT_W - IN_W;

  logic [CHUNKS*OUT_W-1:0] wide;

  generate
    if (PAD == 0) begin : g_exact
      assign wide = din;
    end else begin : g_pad
      assign wide = {{PAD{1'b0}}, din};
    end
  endgenerate

  always_comb begin
    dout = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      dout = dout ^ wide[c*OUT_W +: OUT_W];
    end
  end
endmodule

// File: rtl/tp_hist.sv
module tp_hist #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (shift_en) begin
      hist <= {hist[HIST_W-2:0], bit_in};
    end
  end

  // R8
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(bit_in)) &&
                 (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

  // R8
  hist_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
  parameter int IDX_W   = 6,
  parameter int CTR_W   = 2,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hi,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int             DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX  = '1;
  localparam logic [CTR_W-1:0] CINIT = CTR_W'(RST_VAL);

  logic [DEPTH-1:0][CTR_W-1:0] mem;
  logic [CTR_W-1:0]            cur;
  logic [CTR_W-1:0]            nxt;

  always_comb begin
    cur = mem[wr_idx];
    nxt = cur;
    if (wr_up && (cur != CMAX)) begin
      nxt = cur + 1'b1;
    end else if (!wr_up && (cur != '0)) begin
      nxt = cur - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= CINIT;
      end
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end

  assign rd_hi = mem[rd_idx][CTR_W-1];

  // R6 R7
  ctr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && (mem[wr_idx] == CMAX)) |=> (mem[$past(wr_idx)] == CMAX));

  // R6 R7
  ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && (mem[wr_idx] == '0)) |=> (mem[$past(wr_idx)] == '0));

  // R7
  ctr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W   = 30,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6,
  parameter int CTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PC_W-1:0] req_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic            rsp_p0,
  output logic            rsp_p1,
  output logic            rsp_sel,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_p0,
  input  logic            upd_p1
);
  import tp_pkg::*;

  localparam int WEAK_NT  = (1 << (CTR_W - 1)) - 1;
  localparam int META_W   = 2;
  localparam int META_RST = 1;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  hist_f;
  logic [IDX_W-1:0]  lk_loc, lk_glb;
  logic [IDX_W-1:0]  up_loc, up_glb;
  logic              lk_p0, lk_p1, lk_pick;
  logic              meta_wr, meta_up;
  logic              req_fire;
  pred_s             look, rsp_q;
  logic              rsp_v;

  tp_fold #(.IN_W(PC_W), .OUT_W(IDX_W)) u_fold_lk (.din(req_pc), .dout(lk_loc));
  tp_fold #(.IN_W(PC_W), .OUT_W(IDX_W)) u_fold_up (.din(upd_pc), .dout(up_loc));
  tp_fold #(.IN_W(HIST_W), .OUT_W(IDX_W)) u_fold_h (.din(hist), .dout(hist_f));

  assign lk_glb = lk_loc ^ hist_f;
  assign up_glb = up_loc ^ hist_f;

  tp_hist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .bit_in(upd_taken), .hist(hist)
  );

  tp_sat_table #(.IDX_W(IDX_W), .CTR_W(CTR_W), .RST_VAL(WEAK_NT)) u_local (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_loc), .rd_hi(lk_p0),
    .wr_en(upd_valid), .wr_idx(up_loc), .wr_up(upd_taken)
  );

  tp_sat_table #(.IDX_W(IDX_W), .CTR_W(CTR_W), .RST_VAL(WEAK_NT)) u_global (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_glb), .rd_hi(lk_p1),
    .wr_en(upd_valid), .wr_idx(up_glb), .wr_up(upd_taken)
  );

  assign meta_wr = upd_valid && (upd_p0 != upd_p1);
  assign meta_up = (upd_p1 == upd_taken);

  tp_sat_table #(.IDX_W(IDX_W), .CTR_W(META_W), .RST_VAL(META_RST)) u_meta (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_loc), .rd_hi(lk_pick),
    .wr_en(meta_wr), .wr_idx(up_loc), .wr_up(meta_up)
  );

  always_comb begin
    look.p0    = lk_p0;
    look.p1    = lk_p1;
    look.src   = lk_pick ? SRC_GLOBAL : SRC_LOCAL;
    look.taken = lk_pick ? lk_p1 : lk_p0;
  end

  assign req_ready = !rsp_v || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v <= 1'b0;
      rsp_q <= '0;
    end else if (req_fire) begin
      rsp_v <= 1'b1;
      rsp_q <= look;
    end else if (rsp_ready) begin
      rsp_v <= 1'b0;
    end
  end

  assign rsp_valid = rsp_v;
  assign rsp_taken = rsp_q.taken;
  assign rsp_p0    = rsp_q.p0;
  assign rsp_p1    = rsp_q.p1;
  assign rsp_sel   = (rsp_q.src == SRC_GLOBAL);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_q)));

  // R9
  rsp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R5
  rsp_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_taken == (rsp_sel ? rsp_p1 : rsp_p0)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/sim_tourney_pred.sv
module sim_tourney_pred;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready;
  logic [29:0] req_pc, upd_pc;
  logic        rsp_taken, rsp_p0, rsp_p1, rsp_sel;
  logic        upd_valid, upd_taken, upd_p0, upd_p1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_pred u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(rsp_taken), .rsp_p0(rsp_p0), .rsp_p1(rsp_p1), .rsp_sel(rsp_sel),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_p0(upd_p0), .upd_p1(upd_p1)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_loc[64];
  int m_glb[64];
  int m_ch[64];
  int m_hist;
  bit e_valid, e_taken, e_p0, e_p1, e_sel;
  bit fired_last;

  function automatic int fold30(input logic [29:0] a);
    int r = 0;
    for (int c = 0; c < 5; c++) r = r ^ int'((a >> (6*c)) & 30'h3f);
    return r;
  endfunction

  function automatic int bump(input int v, input bit up, input int top);
    if (up) return (v < top) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  always @(posedge clk) begin : ref_model
    int il, ig;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        m_loc[i] = 1; m_glb[i] = 1; m_ch[i] = 1;
      end
      m_hist = 0; e_valid = 0; fired_last = 0;
      e_taken = 0; e_p0 = 0; e_p1 = 0; e_sel = 0;
    end else begin
      fired_last = req_valid && (!e_valid || rsp_ready);
      if (fired_last) begin
        il = fold30(req_pc);
        ig = il ^ m_hist;
        e_p0 = m_loc[il] >= 2;
        e_p1 = m_glb[ig] >= 2;
        e_sel = m_ch[il] >= 2;
        e_taken = e_sel ? e_p1 : e_p0;
        e_valid = 1;
      end else if (rsp_ready) begin
        e_valid = 0;
      end
      if (upd_valid) begin
        il = fold30(upd_pc);
        ig = il ^ m_hist;
        m_loc[il] = bump(m_loc[il], upd_taken, 3);
        m_glb[ig] = bump(m_glb[ig], upd_taken, 3);
        if (upd_p0 != upd_p1) m_ch[il] = bump(m_ch[il], upd_p1 == upd_taken, 3);
        m_hist = ((m_hist << 1) | int'(upd_taken)) & 63;
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 rsp_valid", rsp_valid, e_valid);
      chk("R9 req_ready", req_ready, !e_valid || rsp_ready);
      if (e_valid) begin
        chk("R2 R6 rsp_p0", rsp_p0, e_p0);
        chk("R3 R6 R8 rsp_p1", rsp_p1, e_p1);
        chk("R4 R7 rsp_sel", rsp_sel, e_sel);
        chk("R5 rsp_taken", rsp_taken, e_taken);
      end
    end
  end

  task automatic lookup(input logic [29:0] pc);
    @(posedge clk); #2;
    req_valid = 1; req_pc = pc; rsp_ready = 1; upd_valid = 0;
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic update(input logic [29:0] pc, input bit t, input bit a, input bit b);
    @(posedge clk); #2;
    upd_valid = 1; upd_pc = pc; upd_taken = t; upd_p0 = a; upd_p1 = b;
    req_valid = 0;
    @(posedge clk); #2;
    upd_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_pc = '0; rsp_ready = 1;
    upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_p0 = 0; upd_p1 = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    chk("R1 rsp_valid after reset", rsp_valid, 1'b0);

    // R1: untouched state predicts not-taken from the local component
    lookup(30'd5);
    chk("R1 p0", rsp_p0, 1'b0);
    chk("R1 p1", rsp_p1, 1'b0);
    chk("R1 sel", rsp_sel, 1'b0);
    chk("R1 taken", rsp_taken, 1'b0);

    // R10: lookup and update of the same address in one cycle
    @(posedge clk); #2;
    req_valid = 1; req_pc = 30'd5; rsp_ready = 1;
    upd_valid = 1; upd_pc = 30'd5; upd_taken = 1; upd_p0 = 0; upd_p1 = 0;
    @(posedge clk); #2;
    req_valid = 0; upd_valid = 0;
    chk("R10 p0 shows old state", rsp_p0, 1'b0);

    // R6: local trained; R3 R8: history now 1 so global index moved to 4
    lookup(30'd5);
    chk("R6 p0 after taken", rsp_p0, 1'b1);
    chk("R3 R8 p1 reindexed", rsp_p1, 1'b0);
    chk("R5 taken follows local", rsp_taken, 1'b1);

    // R7: two disagreements where global was right push chooser to 3
    update(30'd9, 1, 0, 1);
    update(30'd9, 1, 0, 1);
    lookup(30'd9);
    chk("R4 R7 sel global", rsp_sel, 1'b1);
    chk("R2 R6 p0 saturated side", rsp_p0, 1'b1);
    chk("R5 taken follows global", rsp_taken, 1'b0);

    // R7: agreement leaves chooser alone
    update(30'd9, 0, 1, 1);
    lookup(30'd9);
    chk("R7 agree keeps sel", rsp_sel, 1'b1);

    // R7: local right twice steps chooser 3 -> 1
    update(30'd9, 1, 1, 0);
    lookup(30'd9);
    chk("R7 one step back", rsp_sel, 1'b1);
    update(30'd9, 1, 1, 0);
    lookup(30'd9);
    chk("R7 back to local", rsp_sel, 1'b0);

    // R9: stalled consumer
    @(posedge clk); #2;
    req_valid = 1; req_pc = 30'd3; rsp_ready = 0;
    @(posedge clk); #2;
    req_pc = 30'd7;
    @(posedge clk); #2;
    chk("R9 held valid", rsp_valid, 1'b1);
    chk("R9 ready low in stall", req_ready, 1'b0);
    rsp_ready = 1;
    @(posedge clk); #2;
    req_valid = 0;

    // mixed phase, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #2;
      if (!(req_valid && !fired_last)) begin
        req_valid = ($urandom % 3) != 0;
        req_pc = 30'($urandom % 8) | (30'($urandom % 2) << 12);
      end
      rsp_ready = ($urandom % 4) != 0;
      upd_valid = ($urandom % 2) != 0;
      upd_pc = 30'($urandom % 8) | (30'($urandom % 2) << 12);
      upd_taken = (upd_pc[0] ^ (($urandom % 5) == 0));
      upd_p0 = $urandom % 2;
      upd_p1 = $urandom % 2;
    end
    @(posedge clk); #2;
    req_valid = 0; upd_valid = 0; rsp_ready = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule